// File: doc/BRIEF.md
# 8-bit ALU with persistent compare flags

This unit performs the arithmetic and logic work of a small 8-bit core. Each cycle that `issue` is high, it decodes `opCode`, works on the two register values `opA` and `opB`, and reports in the same cycle whether its `result` should be written back. The core writes that result into the register that supplied `opA`. Addition and multiplication keep only the low eight bits. The block has no carry, overflow or signed handling.

A compare never writes a register. It loads a 3-bit status word at the clock edge that closes its cycle. Exactly one bit of that word is set, and the word keeps its value until the next issued compare, so a later conditional branch can read it. Any opcode outside the supported set raises `badOp` for the cycle in which it is issued. It causes no write and does not disturb the status word.

Top module: `alu8_top`

## Requirements
- R1: Opcode 0xA0 (add), when issued, drives `result` = (opA + opB) mod 256 with `wrEn` = 1 in the same cycle.
- R2: Opcodes 0xA8, 0xAA and 0xAB, when issued, drive `result` to the bitwise AND, OR and XOR of opA and opB respectively, with `wrEn` = 1 in the same cycle.
- R3: Opcode 0xA2, when issued, drives `result` to the low 8 bits of the unsigned product opA × opB, with `wrEn` = 1.
- R4: Opcode 0xA7 (compare), when issued, loads `flags` at the next rising clock edge with an unsigned comparison of opA against opB: 3'b100 (bit 2) when opA < opB, 3'b010 (bit 1) when opA > opB, 3'b001 (bit 0) when they are equal.
- R5: An issued compare keeps `wrEn` low and `badOp` low.
- R6: While `rstN` is low, `flags` is 3'b000, and it stays 3'b000 after reset until the first compare.
- R7: `flags` keeps its value across cycles that issue any non-compare opcode, and across cycles with `issue` low, even if `opCode` holds 0xA7.
- R8: An issued opcode outside {0xA0, 0xA2, 0xA7, 0xA8, 0xAA, 0xAB} raises `badOp` for that cycle only, with `wrEn` = 0 and `flags` unchanged.
- R9: With `issue` low, `wrEn` and `badOp` are both 0.
- R10: `result` is 8'h00 in every cycle where `wrEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rstN | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| opCode | input | 8 | Operation select |
| opA | input | 8 | First operand; also the write-back destination's value |
| opB | input | 8 | Second operand |
| result | output | 8 | Value to write back to the opA register |
| wrEn | output | 1 | Write-back enable for the opA register |
| flags | output | 3 | Compare status: bit 2 less, bit 1 greater, bit 0 equal |
| badOp | output | 1 | Issued opcode is not supported |

## Verification
`result`, `wrEn` and `badOp` are combinational, so they are due in the same cycle the operation is presented. `flags` is due one rising edge later. The driver applies each operation just after a falling edge and queues an expected item that holds both the same-cycle values and the status word that should follow. The monitor pops each item, checks the same-cycle outputs a quarter period after the driver's edge, then waits past the next rising edge to compare `flags`. Neither check is sampled at an edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_ADD = 8'hA0;
  localparam logic [OPC_W-1:0] OPC_MUL = 8'hA2;
  localparam logic [OPC_W-1:0] OPC_CMP = 8'hA7;
  localparam logic [OPC_W-1:0] OPC_AND = 8'hA8;
  localparam logic [OPC_W-1:0] OPC_OR  = 8'hAA;
  localparam logic [OPC_W-1:0] OPC_XOR = 8'hAB;

  // status word layout, consumed by branch logic outside this block
  localparam int unsigned FLAG_W  = 3;
  localparam int unsigned FLAG_LT = 2;
  localparam int unsigned FLAG_GT = 1;
  localparam int unsigned FLAG_EQ = 0;

  typedef enum logic [2:0] {
    FN_NONE,
    FN_ADD,
    FN_AND,
    FN_OR,
    FN_XOR,
    FN_MUL,
    FN_CMP
  } aluFn_e;

  typedef struct packed {
    aluFn_e fn;
    logic   wrStb;
    logic   cmpStb;
    logic   badStb;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic             issue,
  input  logic [OPC_W-1:0] opCode,
  output aluStrobe_t       stb
);

  aluFn_e decFn;
  logic   known;

  always_comb begin
    known = 1'b1;
    unique case (opCode)
      OPC_ADD: decFn = FN_ADD;
      OPC_AND: decFn = FN_AND;
      OPC_OR:  decFn = FN_OR;
      OPC_XOR: decFn = FN_XOR;
      OPC_MUL: decFn = FN_MUL;
      OPC_CMP: decFn = FN_CMP;
      default: begin
        decFn = FN_NONE;
        known = 1'b0;
      end
    endcase
  end

  always_comb begin
    stb        = '0;
    stb.fn     = FN_NONE;
    if (issue) begin
      stb.fn     = decFn;
      stb.badStb = !known;
      stb.cmpStb = (decFn == FN_CMP);
      stb.wrStb  = known && (decFn != FN_CMP);
    end
  end

endmodule

// File: rtl/alu8_dpath.sv
module alu8_dpath
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        stb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prodFull;
  logic [DATA_W-1:0] rawResult;
  logic [FLAG_W-1:0] cmpWord;
  logic [FLAG_W-1:0] flagsQ;

  assign prodFull = PROD_W'(opA) * PROD_W'(opB);

  always_comb begin
    unique case (stb.fn)
      FN_ADD:  rawResult = opA + opB;
      FN_AND:  rawResult = opA & opB;
      FN_OR:   rawResult = opA | opB;
      FN_XOR:  rawResult = opA ^ opB;
      FN_MUL:  rawResult = prodFull[DATA_W-1:0];
      default: rawResult = '0;
    endcase
  end

  assign result = stb.wrStb ? rawResult : '0;

  always_comb begin
    cmpWord          = '0;
    cmpWord[FLAG_LT] = (opA < opB);
    cmpWord[FLAG_GT] = (opA > opB);
    cmpWord[FLAG_EQ] = (opA == opB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          flagsQ <= '0;
    else if (stb.cmpStb) flagsQ <= cmpWord;
  end

  assign flags = flagsQ;

  p_flags_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flags));

  p_cmp_loads_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmpStb |=> ($countones(flags) == 1));

  p_cmp_equal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmpStb && (opA == opB)) |=> flags[FLAG_EQ]);

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmpStb |=> $stable(flags));

endmodule

// File: rtl/alu8_top.sv
module alu8_top
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic [FLAG_W-1:0] flags,
  output logic              badOp
);

  aluStrobe_t stb;

  alu8_ctrl u_ctrl (
    .issue  (issue),
    .opCode (opCode),
    .stb    (stb)
  );

  alu8_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .flags  (flags)
  );

  assign wrEn  = stb.wrStb;
  assign badOp = stb.badStb;

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !issue |-> (!wrEn && !badOp));

  p_bad_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    badOp |-> !wrEn);

  p_bad_flags_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    badOp |=> $stable(flags));

  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (issue && (opCode == OPC_CMP)) |-> (!wrEn && !badOp));

  p_result_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (result == '0));

endmodule

// File: tb/sim_alu8_top.sv
module sim_alu8_top;

  localparam int PERIOD = 10;

  typedef struct {
    logic [7:0] res;
    logic       wr;
    logic       bad;
    logic [2:0] flg;
    string      req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       issue = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [7:0] result;
  logic       wrEn;
  logic [2:0] flags;
  logic       badOp;

  expItem_t sb[$];
  logic [2:0] modelFlags = 3'b000;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  alu8_top u0 (
    .clk(clk), .rstN(rstN), .issue(issue), .opCode(opCode),
    .opA(opA), .opB(opB), .result(result), .wrEn(wrEn),
    .flags(flags), .badOp(badOp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit iss, input logic [7:0] opc,
                       input logic [7:0] a, input logic [7:0] b, input string req);
    expItem_t it;
    logic [15:0] prod;
    @(negedge clk);
    issue = iss; opCode = opc; opA = a; opB = b;
    it.res = 8'h00; it.wr = 1'b0; it.bad = 1'b0; it.req = req;
    prod = 16'(a) * 16'(b);
    if (iss) begin
      case (opc)
        8'hA0: begin it.res = 8'(a + b); it.wr = 1'b1; end
        8'hA8: begin it.res = a & b;     it.wr = 1'b1; end
        8'hAA: begin it.res = a | b;     it.wr = 1'b1; end
        8'hAB: begin it.res = a ^ b;     it.wr = 1'b1; end
        8'hA2: begin it.res = prod[7:0]; it.wr = 1'b1; end
        8'hA7: modelFlags = (a < b) ? 3'b100 : (a > b) ? 3'b010 : 3'b001;
        default: it.bad = 1'b1;
      endcase
    end
    it.flg = modelFlags;
    sb.push_back(it);
  endtask

  // monitor: combinational outputs a quarter period after the drive edge,
  // flags a quarter period after the following rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        expItem_t it;
        it = sb.pop_front();
        check(result == it.res, it.req, "result", result, it.res);
        check(wrEn == it.wr, it.req, "wrEn", wrEn, it.wr);
        check(badOp == it.bad, it.req, "badOp", badOp, it.bad);
        @(posedge clk);
        #(PERIOD/4);
        check(flags == it.flg, it.req, "flags", flags, it.flg);
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R6: flags cleared while in reset
    #(PERIOD*2 + PERIOD/4);
    check(flags == 3'b000, "R6", "flags in reset", flags, 0);
    @(negedge clk);
    rstN = 1'b1;
    #(PERIOD/4);
    check(flags == 3'b000, "R6", "flags after reset", flags, 0);

    drive(1, 8'hA0, 8'd5,   8'd3,   "R1");
    drive(1, 8'hA0, 8'd200, 8'd100, "R1");   // wraps to 0x2C
    drive(1, 8'hA8, 8'hF0,  8'h3C,  "R2");
    drive(1, 8'hAA, 8'hF0,  8'h0F,  "R2");
    drive(1, 8'hAB, 8'hAA,  8'hFF,  "R2");
    drive(1, 8'hA2, 8'd20,  8'd13,  "R3");   // 260 -> 4
    drive(1, 8'hA2, 8'hFF,  8'hFF,  "R3");   // 0xFE01 -> 0x01
    drive(1, 8'hA7, 8'd3,   8'd9,   "R4 R5");
    drive(1, 8'hA0, 8'd1,   8'd1,   "R7");
    drive(1, 8'hA7, 8'd9,   8'd3,   "R4 R5");
    drive(1, 8'hA7, 8'h80,  8'h7F,  "R4");   // unsigned: greater
    drive(1, 8'hA7, 8'd7,   8'd7,   "R4");
    drive(1, 8'hA1, 8'd1,   8'd2,   "R8");
    drive(1, 8'h00, 8'd4,   8'd4,   "R8");
    drive(0, 8'hA7, 8'd0,   8'd5,   "R7 R9"); // idle compare opcode ignored
    drive(0, 8'hA0, 8'd6,   8'd6,   "R9 R10");
    drive(1, 8'hA7, 8'd0,   8'd255, "R4");
    drive(1, 8'hFF, 8'd0,   8'd0,   "R8 R10");
    drive(1, 8'hA8, 8'h0F,  8'hF0,  "R2 R10"); // writes zero, flags held
    @(negedge clk);
    issue = 1'b0;
    repeat (3) @(negedge clk);

    // R6: asynchronous reset clears held flags
    rstN = 1'b0;
    #(PERIOD/4);
    check(flags == 3'b000, "R6", "flags after mid-run reset", flags, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule